// File: doc/BRIEF.md
# Neighbourhood Brightness and Contrast Calculator

This block measures the local texture around one pixel. It receives a 3x3 window of 8-bit grey levels. Pixel 4 is the centre and the other eight are its neighbours. It returns two 8-bit figures for the centre:

- **Brightness** is the integer mean of the eight neighbours.
- **Contrast** is the mean of the neighbours at or above the centre, minus the mean of the neighbours below it.

An upstream window fetcher presents the window together with a one-cycle start pulse. Some fixed cycles later, a one-cycle done pulse marks both results as valid.

A single combinational stage sorts the neighbours into the two classes. It does this with eight comparators, two masking banks, adders and a population count. Two restoring shift-subtract dividers then form the two class means in parallel. When a class is empty, its divider sees a zero divisor, and the centre value stands in for that mean. Brightness needs only a shift. The window is sampled once at start, and further start pulses are ignored until the result appears.

Top module: `nbhd_texture_calc`

## Requirements
- R1: Window packing: pixel k (k = 0..8) occupies `win_i[8k+7:8k]`, pixel 4 is the centre, and the other eight are neighbours.
- R2: `bright_o` equals the floor of the sum of the eight neighbours divided by 8; the centre pixel does not contribute.
- R3: A neighbour whose value is greater than or equal to the centre belongs to the upper class; a smaller neighbour belongs to the lower class (ties go upper).
- R4: Each class mean is the floor of the class sum divided by the class size, with the remainder discarded.
- R5: When a class is empty, its mean is taken as the centre value.
- R6: `contrast_o` equals the upper mean minus the lower mean, never negative, in 8 bits.
- R7: `done_o` is a one-cycle pulse that rises exactly 12 clock edges after the edge that accepted start (dividend width 11 plus one result register).
- R8: A start pulse while `busy_o` is high is ignored; `busy_o` is high from the edge after an accepted start until the cycle of `done_o`.
- R9: After reset `busy_o`, `done_o`, `bright_o` and `contrast_o` are 0, and both results hold their value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to sample `win_i` and begin |
| win_i | input | 72 | Nine packed 8-bit pixels, centre at index 4 |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| bright_o | output | 8 | Neighbour mean of the last completed window |
| contrast_o | output | 8 | Upper-class mean minus lower-class mean of the last completed window |

## Verification
The assertions check the handshake on every cycle:

- the fixed start-to-done distance;
- the single-cycle done pulse;
- the entry into busy after an accepted start;
- the two dividers finishing together;
- results that stay put except on a completion cycle.

Only the bench scenarios can show the arithmetic. These include tie classification, an empty upper or lower class with the centre fallback, saturated and zero windows, and floor rounding across pseudo-random windows. The bench also shows that a start pulse during a busy window leaves the result of the first window untouched.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int PIX_W  = 8;
  localparam int NPIX   = 9;
  localparam int CENTRE = 4;
  localparam int NBR    = NPIX - 1;
  localparam int SUM_W  = PIX_W + $clog2(NBR);
  localparam int CNT_W  = $clog2(NBR + 1);
  localparam int WIN_W  = NPIX * PIX_W;
  localparam int SHIFT  = $clog2(NBR);
  localparam int LAT    = SUM_W + 1;

  typedef enum logic {ST_IDLE, ST_RUN} nbc_state_e;
endpackage

// File: rtl/nbc_split.sv
module nbc_split
  import nbc_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output logic [SUM_W-1:0] sum_all,
  output logic [SUM_W-1:0] sum_hi,
  output logic [SUM_W-1:0] sum_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic [CNT_W-1:0] cnt_lo
);
  logic [PIX_W-1:0] ctr;
  logic [PIX_W-1:0] nb   [NBR];
  logic [PIX_W-1:0] hi_t [NBR];
  logic [PIX_W-1:0] lo_t [NBR];
  logic [NBR-1:0]   flag;

  assign ctr = win[CENTRE*PIX_W +: PIX_W];

  for (genvar j = 0; j < NBR; j++) begin : g_nb
    localparam int IDX = (j < CENTRE) ? j : j + 1;
    assign nb[j]   = win[IDX*PIX_W +: PIX_W];
    assign flag[j] = (nb[j] >= ctr);
    assign hi_t[j] = flag[j] ? nb[j] : '0;
    assign lo_t[j] = flag[j] ? '0 : nb[j];
  end

  always_comb begin
    sum_all = '0;
    sum_hi  = '0;
    sum_lo  = '0;
    cnt_hi  = '0;
    for (int j = 0; j < NBR; j++) begin
      sum_all = sum_all + SUM_W'(nb[j]);
      sum_hi  = sum_hi  + SUM_W'(hi_t[j]);
      sum_lo  = sum_lo  + SUM_W'(lo_t[j]);
      cnt_hi  = cnt_hi  + CNT_W'(flag[j]);
    end
    cnt_lo = CNT_W'(NBR) - cnt_hi;
  end
endmodule

// File: rtl/nbc_div.sv
module nbc_div #(
  parameter int DVD_W = 11,
  parameter int DVS_W = 4,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done_o,
  output logic             dz_o,
  output logic [Q_W-1:0]   quot_o
);
  localparam int CW = $clog2(DVD_W + 1);

  logic [DVS_W:0]   rem_q, rem_n;
  logic [DVD_W-1:0] dq_q, dq_n;
  logic [DVS_W-1:0] dvs_q, dvs_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             run_q, run_n, done_q, done_n, dz_q, dz_n;
  logic [DVS_W+1:0] shifted, trial;
  logic             ge;

  always_comb begin
    shifted = {rem_q, dq_q[DVD_W-1]};
    trial   = shifted - {2'b00, dvs_q};
    ge      = ~trial[DVS_W+1];
    rem_n   = rem_q;
    dq_n    = dq_q;
    dvs_n   = dvs_q;
    cnt_n   = cnt_q;
    run_n   = run_q;
    dz_n    = dz_q;
    done_n  = 1'b0;
    if (load) begin
      rem_n = '0;
      dq_n  = dividend;
      dvs_n = divisor;
      cnt_n = CW'(DVD_W);
      run_n = 1'b1;
      dz_n  = (divisor == '0);
    end else if (run_q) begin
      rem_n = ge ? trial[DVS_W:0] : shifted[DVS_W:0];
      dq_n  = {dq_q[DVD_W-2:0], ge};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      dq_q   <= dq_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
      dz_q   <= dz_n;
    end
  end

  assign done_o = done_q;
  assign dz_o   = dz_q;
  assign quot_o = dq_q[Q_W-1:0];
endmodule

// File: rtl/nbhd_texture_calc.sv
module nbhd_texture_calc
  import nbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PIX_W-1:0] bright_o,
  output logic [PIX_W-1:0] contrast_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [SUM_W-1:0] sum_all, sum_hi, sum_lo;
  logic [CNT_W-1:0] cnt_hi, cnt_lo;

  nbc_split u_split (
    .win(win_i), .sum_all(sum_all), .sum_hi(sum_hi), .sum_lo(sum_lo),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
  );

  nbc_state_e       state_q, state_n;
  logic [PIX_W-1:0] ctr_q, ctr_n, pend_q, pend_n;
  logic [PIX_W-1:0] bright_q, bright_n, contr_q, contr_n;
  logic             done_q, done_n, accept, finish;
  logic             div_hi_done, div_lo_done, hi_dz, lo_dz;
  logic [PIX_W-1:0] hi_quot, lo_quot, avg_hi, avg_lo;

  assign accept = start_i && (state_q == ST_IDLE);

  nbc_div #(.DVD_W(SUM_W), .DVS_W(CNT_W), .Q_W(PIX_W)) u_div_hi (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .dividend(sum_hi),
    .divisor(cnt_hi), .done_o(div_hi_done), .dz_o(hi_dz), .quot_o(hi_quot)
  );

  nbc_div #(.DVD_W(SUM_W), .DVS_W(CNT_W), .Q_W(PIX_W)) u_div_lo (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .dividend(sum_lo),
    .divisor(cnt_lo), .done_o(div_lo_done), .dz_o(lo_dz), .quot_o(lo_quot)
  );

  assign finish = div_hi_done && div_lo_done;
  assign avg_hi = hi_dz ? ctr_q : hi_quot;
  assign avg_lo = lo_dz ? ctr_q : lo_quot;

  always_comb begin
    state_n  = state_q;
    ctr_n    = ctr_q;
    pend_n   = pend_q;
    bright_n = bright_q;
    contr_n  = contr_q;
    done_n   = 1'b0;
    if (accept) begin
      state_n = ST_RUN;
      ctr_n   = win_i[CENTRE*PIX_W +: PIX_W];
      pend_n  = sum_all[SHIFT +: PIX_W];
    end else if ((state_q == ST_RUN) && finish) begin
      state_n  = ST_IDLE;
      bright_n = pend_q;
      contr_n  = avg_hi - avg_lo;
      done_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      ctr_q    <= '0;
      pend_q   <= '0;
      bright_q <= '0;
      contr_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      ctr_q    <= ctr_n;
      pend_q   <= pend_n;
      bright_q <= bright_n;
      contr_q  <= contr_n;
      done_q   <= done_n;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign bright_o   = bright_q;
  assign contrast_o = contr_q;
endmodule

// File: rtl/nbc_chk.sv
module nbc_chk
  import nbc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [PIX_W-1:0] bright_o,
  input logic [PIX_W-1:0] contrast_o,
  input logic             hi_done,
  input logic             lo_done
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)             run_cnt <= run_cnt + 8'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == 8'(LAT)));                                        // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                                      // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);                                         // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                                      // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({bright_o, contrast_o}));                             // R9
  AST_DIV_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    hi_done == lo_done);                                                      // R4
endmodule

bind nbhd_texture_calc nbc_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .bright_o(bright_o), .contrast_o(contrast_o),
  .hi_done(div_hi_done), .lo_done(div_lo_done)
);

// File: tb/nbhd_texture_calc_bench.sv
module nbhd_texture_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [71:0] win_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  bright_o, contrast_o;

  int total = 0, bad = 0, cyc = 0, nres = 0, nissue = 0;
  bit ended = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          t0_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nbhd_texture_calc u_nbhd_texture_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_i(win_i),
    .busy_o(busy_o), .done_o(done_o), .bright_o(bright_o), .contrast_o(contrast_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Expected results from the requirements: R2 (brightness), R3 (ties upper), R4/R5 (means), R6.
  function automatic logic [15:0] model(input logic [71:0] w);
    int s = 0, sh = 0, sl = 0, nh = 0, nl = 0, ah, al, c, p;
    c = int'(w[39:32]);
    for (int k = 0; k < 9; k++) begin
      if (k != 4) begin
        p = int'(w[8*k +: 8]);
        s += p;
        if (p >= c) begin sh += p; nh++; end
        else        begin sl += p; nl++; end
      end
    end
    ah = (nh != 0) ? sh / nh : c;
    al = (nl != 0) ? sl / nl : c;
    return {8'(s / 8), 8'(ah - al)};
  endfunction

  function automatic logic [71:0] mkwin(input logic [7:0] ctr, input logic [63:0] nbs);
    return {nbs[63:32], ctr, nbs[31:0]};
  endfunction

  // Monitor: pops the scoreboard on each completion.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 done without accepted start", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        int t0;
        e = exp_q.pop_front(); t = tag_q.pop_front(); t0 = t0_q.pop_front();
        chk(bright_o == e[15:8], {"R2 bright ", t}, bright_o, e[15:8]);
        chk(contrast_o == e[7:0], {"R6 contrast ", t}, contrast_o, e[7:0]);
        chk(cyc - t0 == 13, {"R7 latency ", t}, cyc - t0, 13);
      end
      nres++;
    end
  end

  task automatic issue(input logic [71:0] w, input string t);
    @(negedge clk);
    win_i = w; start_i = 1'b1;
    exp_q.push_back(model(w)); tag_q.push_back(t); t0_q.push_back(cyc);
    nissue++;
    @(negedge clk);
    start_i = 1'b0;
    win_i = ~w;
  endtask

  task automatic run(input logic [71:0] w, input string t);
    issue(w, t);
    wait (nres == nissue);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    logic [71:0] w;
    logic [7:0]  hb, hc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(busy_o == 0, "R9 busy after reset", busy_o, 0);
    chk(done_o == 0, "R9 done after reset", done_o, 0);
    chk(bright_o == 0, "R9 bright after reset", bright_o, 0);
    chk(contrast_o == 0, "R9 contrast after reset", contrast_o, 0);

    // R1 packing: only neighbour 0 nonzero, centre 0 -> bright 1, contrast 1
    run(72'd8, "R1 packing nb0");
    chk(bright_o == 1 && contrast_o == 1, "R1 packing direct", {bright_o, contrast_o}, 16'h0101);
    // R1: centre field carries 200, all neighbours 0 -> bright 0, contrast 200 (upper empty, R5)
    run(mkwin(8'd200, 64'd0), "R1 R5 upper empty");
    chk(contrast_o == 200, "R5 upper empty direct", contrast_o, 200);
    // R3 ties: all equal -> contrast 0
    run({9{8'd100}}, "R3 all equal");
    chk(contrast_o == 0 && bright_o == 100, "R3 ties direct", {bright_o, contrast_o}, {8'd100, 8'd0});
    // R5 lower empty, centre 0
    run(mkwin(8'd0, 64'h0A14_1E28_3250_5A64), "R5 lower empty");
    run({9{8'd255}}, "R4 saturated");
    run(mkwin(8'd128, 64'h80FF_7F00_8101_7E90), "R3 mixed ties");
    run(mkwin(8'd50, 64'h0307_0B31_3233_FEFD), "R4 floor");

    lfsr = 16'hACE1;
    for (int n = 0; n < 8; n++) begin
      for (int b = 0; b < 72; b++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        w[b] = lfsr[0];
      end
      run(w, "R4 random");
    end

    // Back-to-back: start in the done cycle
    issue(mkwin(8'd60, 64'h1020_3040_5060_7080), "R7 b2b first");
    wait (done_o == 1'b1);
    issue(mkwin(8'd90, 64'h0102_0304_F0E0_D0C0), "R7 b2b second");
    wait (nres == nissue);

    // R8: start while busy is ignored
    issue(mkwin(8'd30, 64'h0A0B_0C0D_5051_5253), "R8 first window");
    @(negedge clk);
    chk(busy_o == 1, "R8 busy during run", busy_o, 1);
    win_i = {9{8'd7}}; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait (nres == nissue);
    hb = bright_o; hc = contrast_o;
    repeat (20) @(negedge clk);
    chk(nres == nissue, "R8 no extra result", nres, nissue);
    chk(busy_o == 0, "R8 idle after ignored start", busy_o, 0);
    // R9 hold between completions
    chk(bright_o == hb && contrast_o == hc, "R9 hold", {bright_o, contrast_o}, {hb, hc});

    finish_run();
  end
endmodule